// File: doc/BRIEF.md
# Eight-Channel Output Compare Unit with Master Channel

This block compares eight 16-bit channel values against a free-running count that arrives from outside, and drives one output pin per channel. A channel takes part only when its mode bit selects compare. When the count equals a channel's value, the block raises a one-cycle hit flag for that channel and applies the channel's two-bit action to its pin: hold, toggle, drive low or drive high.

The top channel (index 7) is also a master. A mask picks a set of pins, and a data vector holds a preset level for each of them. When the master matches, each masked pin that is in compare mode loads its preset level. If a channel's own match falls on the same count as the master's, the preset level is loaded first and the channel's own action is then applied to it. The master's own pin takes its preset level when its mask bit is set, and follows its own action when that bit is clear.

Matches are found combinationally. The pins and hit flags are registered, so they change on the clock edge that ends the matching cycle.

Top module: `oc_master_unit`

## Requirements
- R1: While the synchronous active-low reset is asserted at a clock edge, all pins and all hit flags are 0 after that edge.
- R2: When a channel is in compare mode and the count equals its value, its hit flag is 1 for exactly the following cycle, and the pin update happens on the same edge.
- R3: A channel whose mode bit is 0 (capture) raises no hit flag and keeps its pin, even when a master match has its mask bit set.
- R4: The action field of channel x is bits [2x+1:2x] of the action input: 00 leaves the pin unchanged, 01 inverts it, 10 drives it to 0, 11 drives it to 1.
- R5: When mask bit x (x<7) is set and channels 7 and x are both in compare mode, a channel 7 match loads pin x with data bit x.
- R6: When mask bit x (x<7) is clear, a channel 7 match leaves pin x unchanged.
- R7: On a channel 7 match, pin 7 takes data bit 7 when mask bit 7 is set, and ignores its action field. When mask bit 7 is clear, it follows its action field.
- R8: When the channel 7 and channel x matches fall in the same cycle and mask bit x is set, pin x becomes the action of channel x applied to data bit x.
- R9: When the channel 7 and channel x values differ, each match acts on pin x on its own count.
- R10: A hit flag is raised on every match, also when the action field is 00 and the pin does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| count_i | input | 16 | Free-running count value |
| cmp_val_i | input | 128 | Channel compare values, channel x in bits [16x+15:16x] |
| cmp_mode_i | input | 8 | Per-channel select, 1 = compare, 0 = capture |
| act_sel_i | input | 16 | Per-channel two-bit action field |
| mst_mask_i | input | 8 | Pins that the master match may preset |
| mst_data_i | input | 8 | Preset levels for the master match |
| pin_o | output | 8 | Channel output pins |
| hit_o | output | 8 | One-cycle match flags |

## Verification
The count is stepped by hand onto matching and non-matching values. Each pattern targets one behaviour. A single channel cycles through all four actions, which separates the encodings from each other and from a plain hit. A capture-mode channel sits under a master mask, which shows that the mode gate also blocks the override. Master matches run with mixed mask bits, which separates masked pins from unmasked ones. Coincident master and channel matches use data levels chosen so that applying the action to the preset gives a different result from applying it to the old pin. Finally, distinct master and channel values show that the two events stay apart in time.

// File: rtl/oc_pkg.sv
// Package: shared action encoding and the function that applies an action
// to a pin level. Assumes a two-bit action field per channel.
package oc_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'b00,
        ACT_FLIP = 2'b01,
        ACT_LOW  = 2'b10,
        ACT_HIGH = 2'b11
    } act_e;

    // Result of applying action a to level v.
    function automatic logic act_apply(input act_e a, input logic v);
        logic r;
        case (a)
            ACT_HOLD: r = v;
            ACT_FLIP: r = ~v;
            ACT_LOW:  r = 1'b0;
            default:  r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/oc_match.sv
// Module: oc_match
// Finds the channels whose compare value equals the count in this cycle.
// Assumes the compare values are packed with channel x at [W*x +: W].
// A channel in capture mode never reports a match.
module oc_match #(
    parameter int CH = 8,
    parameter int W  = 16
) (
    input  logic [W-1:0]    count_i,
    input  logic [CH*W-1:0] cmp_val_i,
    input  logic [CH-1:0]   cmp_mode_i,
    output logic [CH-1:0]   match_o
);

    // One equality comparator per channel, gated by the mode bit.
    for (genvar i = 0; i < CH; i++) begin : g_cmp
        always_comb begin
            match_o[i] = cmp_mode_i[i] && (cmp_val_i[W*i +: W] == count_i);
        end
    end

endmodule

// File: rtl/oc_pin_cell.sv
// Module: oc_pin_cell
// Holds one output pin. A channel cell loads the master preset level first
// and then applies its own action. The master cell (IS_MASTER=1) takes the
// preset level in place of its own action when its mask bit is set.
// Assumes own_hit_i is already gated by the channel's mode bit.
module oc_pin_cell
    import oc_pkg::*;
#(
    parameter bit IS_MASTER = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic own_hit_i,
    input  logic mst_hit_i,
    input  logic mode_i,
    input  logic mask_i,
    input  logic data_i,
    input  act_e act_i,
    output logic pin_o
);

    logic pin_q;
    logic pin_d;
    logic mst_apply;
    logic base;

    assign mst_apply = mst_hit_i && mask_i && mode_i;

    // Next pin level from the preset and the channel's own action.
    if (IS_MASTER) begin : g_master
        always_comb begin
            base  = pin_q;
            pin_d = mst_apply ? data_i
                  : (own_hit_i ? act_apply(act_i, base) : base);
        end
    end else begin : g_chan
        always_comb begin
            base  = mst_apply ? data_i : pin_q;
            pin_d = own_hit_i ? act_apply(act_i, base) : base;
        end
    end

    // Pin register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_d;
    end

    assign pin_o = pin_q;

    // R6 / R3: with no event the pin keeps its level.
    a_r6_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!own_hit_i && !mst_apply) |=> $stable(pin_q));

    // R4: a lone toggle inverts the pin.
    a_r4_lone_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (own_hit_i && !mst_apply && act_i == ACT_FLIP) |=> (pin_q == !$past(pin_q)));

    if (IS_MASTER) begin : g_master_chk
        // R7: a masked master match loads the preset level whatever the action.
        a_r7_master_pin: assert property (@(posedge clk) disable iff (!rst_n)
            mst_apply |=> (pin_q == $past(data_i)));
    end else begin : g_chan_chk
        // R5: a master match alone loads the preset level.
        a_r5_preset_load: assert property (@(posedge clk) disable iff (!rst_n)
            (mst_apply && !own_hit_i) |=> (pin_q == $past(data_i)));
        // R8: coincident toggle acts on the preset level.
        a_r8_toggle_on_preset: assert property (@(posedge clk) disable iff (!rst_n)
            (mst_apply && own_hit_i && act_i == ACT_FLIP) |=> (pin_q == !$past(data_i)));
    end

endmodule

// File: rtl/oc_master_unit.sv
// Module: oc_master_unit
// Eight-channel output compare unit. The last channel also acts as the master
// that presets masked pins. Matches are found in the current cycle; pins and
// hit flags are registered and change on the following edge.
// Assumes the count is supplied from outside and that compare values, modes,
// actions, mask and data are held stable by the surrounding logic.
module oc_master_unit
    import oc_pkg::*;
#(
    parameter int CH = 8,
    parameter int W  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [W-1:0]    count_i,
    input  logic [CH*W-1:0] cmp_val_i,
    input  logic [CH-1:0]   cmp_mode_i,
    input  logic [2*CH-1:0] act_sel_i,
    input  logic [CH-1:0]   mst_mask_i,
    input  logic [CH-1:0]   mst_data_i,
    output logic [CH-1:0]   pin_o,
    output logic [CH-1:0]   hit_o
);

    localparam int MST = CH - 1;

    logic [CH-1:0] match_c;
    logic [CH-1:0] hit_q;

    oc_match #(.CH(CH), .W(W)) u_match (
        .count_i   (count_i),
        .cmp_val_i (cmp_val_i),
        .cmp_mode_i(cmp_mode_i),
        .match_o   (match_c)
    );

    // One pin cell per channel; the last one is the master variant.
    for (genvar i = 0; i < CH; i++) begin : g_pin
        oc_pin_cell #(.IS_MASTER(i == MST)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .own_hit_i(match_c[i]),
            .mst_hit_i(match_c[MST]),
            .mode_i   (cmp_mode_i[i]),
            .mask_i   (mst_mask_i[i]),
            .data_i   (mst_data_i[i]),
            .act_i    (act_e'(act_sel_i[2*i +: 2])),
            .pin_o    (pin_o[i])
        );
    end

    // Hit flag register, one pulse per match.
    always_ff @(posedge clk) begin
        if (!rst_n) hit_q <= '0;
        else        hit_q <= match_c;
    end

    assign hit_o = hit_q;

    // R1: a reset edge clears all pins and flags.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (pin_o == '0 && hit_q == '0));

    // R2 / R10: a flag appears exactly when the previous count matched.
    a_r2_flag_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (hit_q == $past(match_c)));

    // R3: a capture-mode channel never raises its flag.
    a_r3_capture_silent: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((hit_q & ~$past(cmp_mode_i)) == '0));

endmodule

// File: tb/oc_master_unit_test.sv
module oc_master_unit_test;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [15:0]  count_i;
    logic [127:0] cmp_val_i;
    logic [7:0]   cmp_mode_i;
    logic [15:0]  act_sel_i;
    logic [7:0]   mst_mask_i;
    logic [7:0]   mst_data_i;
    logic [7:0]   pin_o;
    logic [7:0]   hit_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    oc_master_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .count_i   (count_i),
        .cmp_val_i (cmp_val_i),
        .cmp_mode_i(cmp_mode_i),
        .act_sel_i (act_sel_i),
        .mst_mask_i(mst_mask_i),
        .mst_data_i(mst_data_i),
        .pin_o     (pin_o),
        .hit_o     (hit_o)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic set_cmp(input int ch, input logic [15:0] v);
        cmp_val_i[16*ch +: 16] = v;
    endtask

    task automatic set_act(input int ch, input logic [1:0] a);
        act_sel_i[2*ch +: 2] = a;
    endtask

    // Drive a count value and move to the next falling edge.
    task automatic step(input logic [15:0] v);
        count_i = v;
        @(negedge clk);
    endtask

    task automatic do_reset;
        rst_n      = 1'b0;
        count_i    = 16'd1000;
        cmp_val_i  = {8{16'hFFFF}};
        cmp_mode_i = 8'hFF;
        act_sel_i  = '0;
        mst_mask_i = '0;
        mst_data_i = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset;
        do_reset();
        set_cmp(0, 16'd5); set_act(0, 2'b11);
        step(16'd5);
        check("R1", "pin before reset", pin_o, 8'h01);
        rst_n = 1'b0;
        step(16'd5);
        check("R1", "pins after reset", pin_o, 8'h00);
        check("R1", "flags after reset", hit_o, 8'h00);
        rst_n = 1'b1;
    endtask

    task automatic t_actions;
        do_reset();
        set_cmp(0, 16'd10); set_act(0, 2'b11);
        step(16'd10);
        check("R4", "set action", pin_o, 8'h01);
        check("R2", "flag on match", hit_o, 8'h01);
        step(16'd11);
        check("R2", "flag lasts one cycle", hit_o, 8'h00);
        check("R2", "pin held off match", pin_o, 8'h01);
        set_act(0, 2'b01);
        step(16'd10);
        check("R4", "toggle to 0", pin_o, 8'h00);
        step(16'd11);
        step(16'd10);
        check("R4", "toggle to 1", pin_o, 8'h01);
        step(16'd11);
        set_act(0, 2'b10);
        step(16'd10);
        check("R4", "clear action", pin_o, 8'h00);
        step(16'd11);
        set_act(0, 2'b11);
        step(16'd10);
        step(16'd11);
        set_act(0, 2'b00);
        step(16'd10);
        check("R4", "hold action", pin_o, 8'h01);
        check("R10", "flag with hold action", hit_o, 8'h01);
    endtask

    task automatic t_capture;
        do_reset();
        cmp_mode_i = 8'b1111_1101;
        set_cmp(1, 16'd20); set_act(1, 2'b11);
        step(16'd20);
        check("R3", "capture channel flag", hit_o, 8'h00);
        check("R3", "capture channel pin", pin_o, 8'h00);
        set_cmp(7, 16'd30);
        mst_mask_i = 8'b0000_0010; mst_data_i = 8'b0000_0010;
        step(16'd30);
        check("R3", "capture channel under mask", pin_o, 8'h00);
        check("R3", "master flag only", hit_o, 8'h80);
    endtask

    task automatic t_master;
        do_reset();
        set_cmp(7, 16'd40);
        mst_mask_i = 8'b0000_0110;
        mst_data_i = 8'b0000_1010;
        set_act(3, 2'b11);
        step(16'd40);
        check("R5", "masked pins preset", pin_o, 8'b0000_0010);
        check("R6", "unmasked pin 3 untouched", pin_o & 8'h08, 8'h00);
        step(16'd41);
        mst_data_i = 8'b0000_0100;
        step(16'd40);
        check("R5", "preset levels swapped", pin_o, 8'b0000_0100);
    endtask

    task automatic t_pin7;
        do_reset();
        set_cmp(7, 16'd50);
        mst_mask_i = 8'h80; mst_data_i = 8'h80; set_act(7, 2'b10);
        step(16'd50);
        check("R7", "pin 7 takes preset", pin_o, 8'h80);
        step(16'd51);
        mst_mask_i = 8'h00; set_act(7, 2'b01);
        step(16'd50);
        check("R7", "pin 7 follows action", pin_o, 8'h00);
    endtask

    task automatic t_same;
        do_reset();
        set_cmp(7, 16'd60); set_cmp(4, 16'd60);
        mst_mask_i = 8'h10;
        mst_data_i = 8'h10; set_act(4, 2'b01);
        step(16'd60);
        check("R8", "toggle applied to preset", pin_o, 8'h00);
        check("R8", "both flags", hit_o, 8'h90);
        step(16'd61);
        mst_data_i = 8'h00; set_act(4, 2'b11);
        step(16'd60);
        check("R8", "set over preset 0", pin_o, 8'h10);
        step(16'd61);
        mst_data_i = 8'h10; set_act(4, 2'b10);
        step(16'd60);
        check("R8", "clear over preset 1", pin_o, 8'h00);
        step(16'd61);
        set_act(4, 2'b00);
        step(16'd60);
        check("R8", "hold keeps preset", pin_o, 8'h10);
    endtask

    task automatic t_separate;
        do_reset();
        set_cmp(7, 16'd70); set_cmp(5, 16'd75);
        mst_mask_i = 8'h20; mst_data_i = 8'h20; set_act(5, 2'b01);
        step(16'd70);
        check("R9", "master event alone", pin_o, 8'h20);
        step(16'd72);
        check("R9", "no event between", pin_o, 8'h20);
        step(16'd75);
        check("R9", "own toggle later", pin_o, 8'h00);
        check("R9", "own flag later", hit_o, 8'h20);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        @(negedge clk);
        do_reset();
        check("R1", "pins at start", pin_o, 8'h00);
        check("R1", "flags at start", hit_o, 8'h00);
        t_reset();
        t_actions();
        t_capture();
        t_master();
        t_pin7();
        t_same();
        t_separate();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule